// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block converts one pulse-width request bit into two gate enables, one for the high-side switch and one for the low-side switch of a synchronous buck stage. The two enables never overlap. Neither switch is turned on after a fixed delay. Each turn-on waits for sensed evidence that the opposite switch has really gone off. The high side waits for the low-gate node to read low. The low side waits for the phase node to read low.

When the inductor current is negative, the phase node may never fall after the high side opens. A watchdog therefore turns the low side on anyway after a fixed number of clock cycles. A free-running period counter caps the high-side on time at a fraction of the switching period.

Startup logic can hold the low side off through a mask. Protection logic owns two commands. One forces both gates off. The other forces the low side on. Both act in the same cycle, whatever the sequencing state.

Top module: `adt_gate_seq`

## Requirements
- R1: After the high gate is removed, the low gate is applied only in a cycle that follows a cycle in which `phase_low` was 1 (or the R3 watchdog expired).
- R2: The high gate is applied only in a cycle that follows a cycle in which `lgate_low` was 1, while `pwm_req` is 1.
- R3: If `phase_low` stays 0 after the high gate is removed, the low gate comes on exactly `WD_CYC` clock cycles after the high gate fell. The count restarts from zero at every high-gate turn-off.
- R4: `ls_allow` = 0 holds the low gate off without changing the high gate or the sequencing. Setting `ls_allow` back to 1 while the sequencer is in its low-side phase brings the low gate on at once.
- R5: `prot_ls_on` = 1 (with `prot_off` = 0) drives the low gate on and the high gate off in the same cycle. This happens regardless of `ls_allow` and of the sequencing state.
- R6: `prot_off` = 1 drives both gates off in the same cycle and takes priority over `prot_ls_on`. After any protection command, the sequencer waits for `lgate_low` before applying the high gate again.
- R7: The high gate is never on in period cycles at or beyond `PERIOD_CYC*MAX_DUTY_PCT/100`. With `pwm_req`, `phase_low` and `lgate_low` all held at 1, the high gate is on for exactly that count minus one cycles in every period.
- R8: `hs_on` and `ls_on` are never both 1.
- R9: During reset both gates are off. The sequencer restarts in the state that waits to apply the high gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_req | input | 1 | Modulator request: 1 asks for the high side, 0 for the low side |
| phase_low | input | 1 | Switching node sensed below its low threshold |
| lgate_low | input | 1 | Low-side gate node sensed low (low switch is off) |
| ls_allow | input | 1 | Startup mask: 0 keeps the low gate off |
| prot_off | input | 1 | Protection: remove both gates immediately |
| prot_ls_on | input | 1 | Protection: force the low gate on, high gate off |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
Two functions can collide in one cycle: the duty limit closing the high-side window, and the protection override landing while the high gate is on. The bench waits for the high gate to rise, then raises `prot_off` or `prot_ls_on` in the middle of that cycle. It judges the outputs before the next edge, so the override is seen to act at once and is not deferred to the sequencer's next registered state. A separate run holds every input permissive across several periods and counts high-gate cycles per period. This shows that the window limit, not the handshake, ends each pulse. The bench also checks that the two gates never overlap at any sampled point.

// File: rtl/adt_seq_pkg.sv
package adt_seq_pkg;

    // Sequencer phases; the two ARM states keep both gates off while
    // waiting for the opposite switch to be sensed off.
    typedef enum logic [1:0] {
        ST_ARM_HI = 2'd0,
        ST_HI     = 2'd1,
        ST_ARM_LO = 2'd2,
        ST_LO     = 2'd3
    } seq_state_e;

endpackage

// File: rtl/adt_period.sv
module adt_period #(
    parameter int PERIOD_CYC   = 20,
    parameter int MAX_DUTY_PCT = 80
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_now,
    output logic win_next
);
    localparam int CW     = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam int MAX_ON = (PERIOD_CYC * MAX_DUTY_PCT) / 100;
    localparam logic [CW-1:0] LAST_C   = CW'(PERIOD_CYC - 1);
    localparam logic [CW-1:0] MAX_ON_C = CW'(MAX_ON);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST_C) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign win_now  = (cnt_q < MAX_ON_C);
    assign win_next = (cnt_d < MAX_ON_C);

endmodule

// File: rtl/adt_watchdog.sv
module adt_watchdog #(
    parameter int WD_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int WW = $clog2(WD_CYC + 1);
    localparam logic [WW-1:0] LIM_C = WW'(WD_CYC - 1);

    logic [WW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = arm ? cnt_q + WW'(1) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = arm && (cnt_q == LIM_C);

    // The sequencer must leave the wait state when the count expires.
    AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (cnt_q <= LIM_C)); // R3

endmodule

// File: rtl/adt_seq_fsm.sv
module adt_seq_fsm
    import adt_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_req,
    input  logic       phase_low,
    input  logic       lgate_low,
    input  logic       win_next,
    input  logic       wd_expired,
    input  logic       prot_any,
    output seq_state_e state
);
    seq_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (prot_any) begin
            state_d = ST_ARM_HI;
        end else begin
            unique case (state_q)
                ST_ARM_HI: begin
                    if (!pwm_req)                    state_d = ST_ARM_LO;
                    else if (win_next && lgate_low)  state_d = ST_HI;
                end
                ST_HI: begin
                    if (!pwm_req || !win_next)       state_d = ST_ARM_LO;
                end
                ST_ARM_LO: begin
                    if (phase_low || wd_expired)     state_d = ST_LO;
                end
                ST_LO: begin
                    if (pwm_req && win_next)         state_d = ST_ARM_HI;
                end
                default: state_d = ST_ARM_HI;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARM_HI;
        else        state_q <= state_d;
    end

    assign state = state_q;

    AST_LO_WAITS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM_LO && !phase_low && !wd_expired && !prot_any)
        |=> (state_q != ST_LO)); // R1

    AST_HI_WAITS_LGATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM_HI && !lgate_low) |=> (state_q != ST_HI)); // R2

    AST_PROT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        prot_any |=> (state_q == ST_ARM_HI)); // R6

endmodule

// File: rtl/adt_gate_drive.sv
module adt_gate_drive
    import adt_seq_pkg::*;
(
    input  seq_state_e state,
    input  logic       ls_allow,
    input  logic       prot_off,
    input  logic       prot_ls_on,
    output logic       hs_on,
    output logic       ls_on
);
    always_comb begin
        hs_on = (state == ST_HI) && !prot_off && !prot_ls_on;
        ls_on = !prot_off && (prot_ls_on || ((state == ST_LO) && ls_allow));
    end

endmodule

// File: rtl/adt_gate_seq.sv
module adt_gate_seq
    import adt_seq_pkg::*;
#(
    parameter int PERIOD_CYC   = 20,
    parameter int MAX_DUTY_PCT = 80,
    parameter int WD_CYC       = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic phase_low,
    input  logic lgate_low,
    input  logic ls_allow,
    input  logic prot_off,
    input  logic prot_ls_on,
    output logic hs_on,
    output logic ls_on
);
    logic       win_now, win_next, wd_expired, prot_any;
    seq_state_e state;

    assign prot_any = prot_off || prot_ls_on;

    adt_period #(
        .PERIOD_CYC  (PERIOD_CYC),
        .MAX_DUTY_PCT(MAX_DUTY_PCT)
    ) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_now (win_now),
        .win_next(win_next)
    );

    adt_watchdog #(
        .WD_CYC(WD_CYC)
    ) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (state == ST_ARM_LO),
        .expired(wd_expired)
    );

    adt_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_req   (pwm_req),
        .phase_low (phase_low),
        .lgate_low (lgate_low),
        .win_next  (win_next),
        .wd_expired(wd_expired),
        .prot_any  (prot_any),
        .state     (state)
    );

    adt_gate_drive u_drive (
        .state     (state),
        .ls_allow  (ls_allow),
        .prot_off  (prot_off),
        .prot_ls_on(prot_ls_on),
        .hs_on     (hs_on),
        .ls_on     (ls_on)
    );

    AST_GATES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on)); // R8

    AST_DUTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on |-> win_now); // R7

endmodule

// File: tb/tb_adt_gate_seq.sv
module tb_adt_gate_seq;
    localparam int PERIOD_CYC   = 20;
    localparam int MAX_DUTY_PCT = 80;
    localparam int WD_CYC       = 6;
    localparam int EXP_ON       = (PERIOD_CYC * MAX_DUTY_PCT) / 100 - 1;

    logic clk = 1'b0;
    logic rst_n, pwm_req, phase_low, lgate_low, ls_allow, prot_off, prot_ls_on;
    logic hs_on, ls_on;
    int   n_checks = 0;
    int   n_err    = 0;
    int   overlap  = 0;

    always #4 clk = ~clk;

    adt_gate_seq #(
        .PERIOD_CYC  (PERIOD_CYC),
        .MAX_DUTY_PCT(MAX_DUTY_PCT),
        .WD_CYC      (WD_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .phase_low(phase_low),
        .lgate_low(lgate_low), .ls_allow(ls_allow), .prot_off(prot_off),
        .prot_ls_on(prot_ls_on), .hs_on(hs_on), .ls_on(ls_on)
    );

    // Vector: [11:8] requirement, [7:2] pwm,phase,lgate,allow,off,lson, [1:0] hs,ls
    localparam logic [11:0] VEC [0:14] = '{
        {4'd2, 6'b100100, 2'b00},  // R2 lgate not low: wait
        {4'd2, 6'b101100, 2'b10},  // R2 lgate low: high on
        {4'd2, 6'b101100, 2'b10},  // R2 hold
        {4'd1, 6'b001100, 2'b00},  // R1 request drops, phase high
        {4'd1, 6'b001100, 2'b00},  // R1 still waiting
        {4'd1, 6'b011100, 2'b01},  // R1 phase low: low on
        {4'd2, 6'b110100, 2'b00},  // R2 request, low removed
        {4'd2, 6'b110100, 2'b00},  // R2 lgate still high
        {4'd2, 6'b111100, 2'b10},  // R2 lgate low: high on
        {4'd4, 6'b101000, 2'b10},  // R4 mask leaves high gate alone
        {4'd1, 6'b011000, 2'b00},  // R1 high removed
        {4'd4, 6'b011000, 2'b00},  // R4 low phase reached but masked
        {4'd4, 6'b011100, 2'b01},  // R4 mask released
        {4'd5, 6'b011001, 2'b01},  // R5 forced on over mask
        {4'd6, 6'b011110, 2'b00}   // R6 force off
    };

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic wait_hs(input string tag);
        for (int k = 0; k < 60 && !hs_on; k++) @(negedge clk);
        chk(tag, hs_on, 1'b1, "high gate reached");
    endtask

    always @(negedge clk) if (rst_n === 1'b1 && hs_on && ls_on) overlap++;

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int cnt, run, max_run;
        rst_n = 1'b0; pwm_req = 1'b0; phase_low = 1'b0; lgate_low = 1'b0;
        ls_allow = 1'b1; prot_off = 1'b0; prot_ls_on = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", hs_on, 1'b0, "reset high gate");
        chk("R9", ls_on, 1'b0, "reset low gate");
        rst_n = 1'b1;

        for (int i = 0; i < 15; i++) begin
            {pwm_req, phase_low, lgate_low, ls_allow, prot_off, prot_ls_on} = VEC[i][7:2];
            @(negedge clk);
            n_checks++;
            if ({hs_on, ls_on} !== VEC[i][1:0]) begin
                n_err++;
                $display("FAIL R%0d step %0d: actual=%b expected=%b",
                         VEC[i][11:8], i, {hs_on, ls_on}, VEC[i][1:0]);
            end
        end

        // R6: force-off lands while the high gate is on
        prot_off = 1'b0; ls_allow = 1'b1; pwm_req = 1'b1; lgate_low = 1'b1; phase_low = 1'b0;
        wait_hs("R6");
        prot_off = 1'b1; #1;
        chk("R6", hs_on, 1'b0, "high gate same cycle");
        chk("R6", ls_on, 1'b0, "low gate same cycle");
        prot_ls_on = 1'b1; #1;
        chk("R6", ls_on, 1'b0, "off beats force-low");
        prot_ls_on = 1'b0; lgate_low = 1'b0;
        @(negedge clk); prot_off = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6", hs_on, 1'b0, "rearm waits for lgate");

        // R5: force-low lands while the high gate is on
        lgate_low = 1'b1;
        wait_hs("R5");
        prot_ls_on = 1'b1; #1;
        chk("R5", hs_on, 1'b0, "high gate same cycle");
        chk("R5", ls_on, 1'b1, "low gate same cycle");
        @(negedge clk); prot_ls_on = 1'b0;

        // R3: phase never falls, twice in a row
        for (int rep = 0; rep < 2; rep++) begin
            pwm_req = 1'b1; phase_low = 1'b0;
            wait_hs("R3");
            pwm_req = 1'b0;
            for (int k = 1; k <= WD_CYC; k++) begin
                @(negedge clk);
                if (k == WD_CYC) chk("R3", ls_on, 1'b0, "low gate before timeout");
            end
            @(negedge clk);
            chk("R3", ls_on, 1'b1, "low gate at timeout");
        end

        // R7: all inputs permissive, count high cycles over three periods
        pwm_req = 1'b1; phase_low = 1'b1; lgate_low = 1'b1; ls_allow = 1'b1;
        repeat (40) @(negedge clk);
        cnt = 0; run = 0; max_run = 0;
        for (int k = 0; k < 3 * PERIOD_CYC; k++) begin
            @(negedge clk);
            if (hs_on) begin cnt++; run++; if (run > max_run) max_run = run; end
            else run = 0;
        end
        n_checks++;
        if (cnt != 3 * EXP_ON) begin
            n_err++;
            $display("FAIL R7 high cycles: actual=%0d expected=%0d", cnt, 3 * EXP_ON);
        end
        n_checks++;
        if (max_run != EXP_ON) begin
            n_err++;
            $display("FAIL R7 longest pulse: actual=%0d expected=%0d", max_run, EXP_ON);
        end

        n_checks++;
        if (overlap != 0) begin
            n_err++;
            $display("FAIL R8 overlap cycles: actual=%0d expected=0", overlap);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule